// File: doc/BRIEF.md
# Dual-Channel Serial DAC Load Controller

This block is the digital front end of a two-channel 12-bit voltage-output converter. A host sends 16-bit command words over a three-wire link: a serial clock, a data line and an active-low select. Each word carries a 12-bit code, two channel address flags and a mode flag. The bits shifted out of the word register appear on a serial output pin. Several controllers can therefore sit in a daisy chain under one shared select. Two active-low load strobes then move the 12-bit code from the word register into the first channel's holding register, the second channel's, or both. The two 12-bit holding register values are the block's outputs, and they feed the converter cores outside the block.

Every serial and strobe input is brought into the system clock domain through a synchroniser and edge-detected. A small load sequencer tracks each frame. It has three states. ST_IDLE means the select is high and loads are accepted. ST_SHIFT means a frame is in progress. ST_FAULT means a strobe went low during a frame, so that frame's word is discarded. The transitions are:

- ST_IDLE to ST_SHIFT when the synchronised select is low.
- ST_SHIFT to ST_FAULT when either strobe is low.
- ST_SHIFT to ST_IDLE when the select returns high with both strobes high.
- ST_FAULT to ST_SHIFT only on a fresh falling edge of the select.

An asynchronous active-low reset puts both holding registers at zero code or at midscale, depending on a static pin.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `rst_n` is low, both holding registers take their reset value at once, without a clock edge. The value is 0x000 when `mid_sel` is 0 and 0x800 when `mid_sel` is 1. The word register and `sdata_out` are cleared to 0.
- R2: The word register shifts only on rising `sclk` edges while `cs_n` is low. `sclk` activity while `cs_n` is high leaves the stored word unchanged.
- R3: The word is received most significant bit first. Bit 15 is the mode flag (0 = strobe-select, 1 = address-select). Bit 14 is address flag A and bit 13 is address flag B. Bits 11..0 are the code.
- R4: In strobe-select mode, a falling edge on `lda_n` loads the code into channel A only. A falling edge on `ldb_n` loads channel B only. Falling edges on both load both.
- R5: In address-select mode, a falling edge on either strobe (or both together) loads the code according to the address flags. A=1,B=0 loads channel A. A=0,B=1 loads channel B. A=1,B=1 loads both. A=0,B=0 loads neither.
- R6: If either strobe is low while a frame is being shifted, the frame is discarded. Strobe edges cause no load until a new frame starts with a fresh falling edge of `cs_n`. No holding register changes during any frame.
- R7: `sdata_out` changes only on falling `sclk` edges within a frame. Over the next 16-bit frame, it presents the previously held word MSB first, so a downstream device captures it exactly.
- R8: Bit 12 of the word has no effect on the loaded code or on the channel selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample all serial and strobe inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| mid_sel | input | 1 | Static reset-level select: 0 gives zero code, 1 gives midscale |
| sclk | input | 1 | Serial clock from the host |
| sdata_in | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select |
| lda_n | input | 1 | Active-low load strobe, channel A |
| ldb_n | input | 1 | Active-low load strobe, channel B |
| sdata_out | output | 1 | Serial data toward the next device in a chain |
| dac_a | output | 12 | Channel A holding register |
| dac_b | output | 12 | Channel B holding register |

## Verification
The bench first goes after address decoding in address-select mode, including the A=0,B=0 code. A design that fell back to strobe-select behaviour there would load a channel when none should change. It then pulls a strobe low mid-frame and strobes again after the select rises. A design without the fault state would load a half-formed word. Clock pulses are sent with the select high before a frame. A design that shifted regardless of select would corrupt both the next load and the daisy-chain output. Each frame's serial output is compared against the previous word, which catches an off-by-one in the output timing. Asynchronous resets to both levels are checked without any clock edge.

// File: rtl/dac_if_pkg.sv
`timescale 1ns/1ps
package dac_if_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FAULT = 2'd2
    } ld_state_e;

    localparam int IN_SCLK = 4;
    localparam int IN_SDI  = 3;
    localparam int IN_CS   = 2;
    localparam int IN_LDA  = 1;
    localparam int IN_LDB  = 0;
    localparam int IN_W    = 5;
    localparam int CTRL_BITS = 4;
endpackage

// File: rtl/dac_in_sync.sv
`timescale 1ns/1ps
module dac_in_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] pipe [0:STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/dac_shift_reg.sv
`timescale 1ns/1ps
module dac_shift_reg #(
    parameter int DATA_W = 12,
    parameter int WORD_W = DATA_W + dac_if_pkg::CTRL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              drive_en,
    input  logic              sdi,
    output logic              mode,
    output logic              addr_a,
    output logic              addr_b,
    output logic [DATA_W-1:0] data,
    output logic              sdo
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sdo <= 1'b0;
        else if (drive_en) sdo <= sr_q[WORD_W-1];
    end

    assign mode   = sr_q[WORD_W-1];
    assign addr_a = sr_q[WORD_W-2];
    assign addr_b = sr_q[WORD_W-3];
    assign data   = sr_q[DATA_W-1:0];
endmodule

// File: rtl/dac_load_ctrl.sv
`timescale 1ns/1ps
module dac_load_ctrl
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_sel,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              lda_low,
    input  logic              ldb_low,
    input  logic              lda_fall,
    input  logic              ldb_fall,
    input  logic              mode,
    input  logic              addr_a,
    input  logic              addr_b,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    ld_state_e state_q, state_d;
    logic      ld_a, ld_b;
    logic [DATA_W-1:0] rst_code;

    assign rst_code = mid_sel ? MID_CODE : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_low) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (lda_low || ldb_low) state_d = ST_FAULT;
                else if (!cs_low)       state_d = ST_IDLE;
            end
            ST_FAULT: if (cs_fall) state_d = ST_SHIFT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ld_a = 1'b0;
        ld_b = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mode) begin
                    if (lda_fall || ldb_fall) begin
                        ld_a = addr_a;
                        ld_b = addr_b;
                    end
                end else begin
                    ld_a = lda_fall;
                    ld_b = ldb_fall;
                end
            end
            ST_SHIFT, ST_FAULT: begin
                ld_a = 1'b0;
                ld_b = 1'b0;
            end
            default: begin
                ld_a = 1'b0;
                ld_b = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_a <= rst_code;
            dac_b <= rst_code;
        end else begin
            if (ld_a) dac_a <= data;
            if (ld_b) dac_b <= data;
        end
    end

    // R6: no holding register moves while a frame is open or discarded
    a_r6_quiet_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(dac_a) && $stable(dac_b)));

    // R4: strobe-select mode with only the A strobe leaves channel B alone
    a_r4_hw_a_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !mode && lda_fall && !ldb_fall) |=> $stable(dac_b));

    // R5: address code 00 in address-select mode loads nothing
    a_r5_sw_none: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mode && !addr_a && !addr_b && (lda_fall || ldb_fall))
        |=> ($stable(dac_a) && $stable(dac_b)));

    // R6: entering the discard state needs a strobe low during a frame
    a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !lda_low && !ldb_low) |=> (state_q != ST_FAULT));
endmodule

// File: rtl/dual_dac_serial_if.sv
`timescale 1ns/1ps
module dual_dac_serial_if
    import dac_if_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_sel,
    input  logic              sclk,
    input  logic              sdata_in,
    input  logic              cs_n,
    input  logic              lda_n,
    input  logic              ldb_n,
    output logic              sdata_out,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b
);
    localparam int WORD_W = DATA_W + CTRL_BITS;
    localparam logic [IN_W-1:0] IN_IDLE = 5'b00111;

    logic [IN_W-1:0] raw_in, s_q, s_prev;
    logic sclk_rise, sclk_fall, cs_low, cs_fall;
    logic lda_fall, ldb_fall;
    logic w_mode, w_addr_a, w_addr_b;
    logic [DATA_W-1:0] w_data;
    logic unused_sync;

    assign raw_in = {sclk, sdata_in, cs_n, lda_n, ldb_n};

    dac_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q(s_q), .q_prev(s_prev)
    );

    assign sclk_rise   = s_q[IN_SCLK] & ~s_prev[IN_SCLK];
    assign sclk_fall   = ~s_q[IN_SCLK] & s_prev[IN_SCLK];
    assign cs_low      = ~s_q[IN_CS];
    assign cs_fall     = ~s_q[IN_CS] & s_prev[IN_CS];
    assign lda_fall    = ~s_q[IN_LDA] & s_prev[IN_LDA];
    assign ldb_fall    = ~s_q[IN_LDB] & s_prev[IN_LDB];
    assign unused_sync = s_prev[IN_SDI];

    dac_shift_reg #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(sclk_rise & cs_low),
        .drive_en(sclk_fall & cs_low),
        .sdi(s_q[IN_SDI]),
        .mode(w_mode), .addr_a(w_addr_a), .addr_b(w_addr_b),
        .data(w_data), .sdo(sdata_out)
    );

    dac_load_ctrl #(.DATA_W(DATA_W)) u_load (
        .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel),
        .cs_low(cs_low), .cs_fall(cs_fall),
        .lda_low(~s_q[IN_LDA]), .ldb_low(~s_q[IN_LDB]),
        .lda_fall(lda_fall), .ldb_fall(ldb_fall),
        .mode(w_mode), .addr_a(w_addr_a), .addr_b(w_addr_b),
        .data(w_data), .dac_a(dac_a), .dac_b(dac_b)
    );

    // R2: with select high the received word does not move
    a_r2_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> $stable({w_mode, w_addr_a, w_addr_b, w_data}));

    // R7: the chain output only moves on a falling serial clock
    a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdata_out));
endmodule

// File: tb/dual_dac_serial_if_tb.sv
`timescale 1ns/1ps
module dual_dac_serial_if_tb;
    logic clk = 1'b0;
    logic rst_n, mid_sel, sclk, sdata_in, cs_n, lda_n, ldb_n;
    logic sdata_out;
    logic [11:0] dac_a, dac_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] prev_word;
    logic [15:0] cur_word;
    logic [11:0] exp_a, exp_b;
    bit          discarded;

    always #2.5 clk = ~clk;

    dual_dac_serial_if u_dut (
        .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .sclk(sclk),
        .sdata_in(sdata_in), .cs_n(cs_n), .lda_n(lda_n), .ldb_n(ldb_n),
        .sdata_out(sdata_out), .dac_a(dac_a), .dac_b(dac_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk({req, " chA"}, {4'h0, dac_a}, {4'h0, exp_a});
        chk({req, " chB"}, {4'h0, dac_b}, {4'h0, exp_b});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // R2/R3/R6/R7: one frame, MSB first; optional strobe violation at bit fault_bit
    task automatic send_word(input logic [15:0] w, input int fault_bit);
        logic [15:0] cap;
        cap = '0;
        cs_n = 1'b0;
        tick(6);
        for (int i = 15; i >= 0; i--) begin
            sdata_in = w[i];
            if (i == fault_bit) lda_n = 1'b0;
            tick(6);
            cap = {cap[14:0], sdata_out};
            sclk = 1'b1;
            tick(6);
            sclk = 1'b0;
        end
        tick(6);
        cs_n = 1'b1;
        tick(6);
        lda_n = 1'b1;
        tick(8);
        chk("R7 chain output", cap, prev_word);
        chk_regs("R6 no load during frame");
        prev_word = w;
        cur_word  = w;
        discarded = (fault_bit >= 0);
    endtask

    task automatic strobe(input bit a, input bit b);
        lda_n = ~a;
        ldb_n = ~b;
        tick(8);
        lda_n = 1'b1;
        ldb_n = 1'b1;
        tick(8);
        if (discarded) begin
            chk_regs("R6 discarded frame");
        end else if (cur_word[15]) begin
            if (a || b) begin
                if (cur_word[14]) exp_a = cur_word[11:0];
                if (cur_word[13]) exp_b = cur_word[11:0];
            end
            chk_regs("R5/R3/R8 address-select load");
        end else begin
            if (a) exp_a = cur_word[11:0];
            if (b) exp_b = cur_word[11:0];
            chk_regs("R4/R3/R8 strobe-select load");
        end
    endtask

    task automatic do_reset(input bit mid);
        @(negedge clk);
        mid_sel = mid;
        #1 rst_n = 1'b0;
        #0.5;
        exp_a = mid ? 12'h800 : 12'h000;
        exp_b = exp_a;
        chk_regs("R1 async reset level");
        chk("R1 sdo reset", {15'h0, sdata_out}, 16'h0);
        tick(3);
        rst_n = 1'b1;
        tick(4);
        prev_word = '0;
        cur_word  = '0;
        discarded = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mid_sel = 1'b0; sclk = 1'b0; sdata_in = 1'b0;
        cs_n = 1'b1; lda_n = 1'b1; ldb_n = 1'b1;
        prev_word = '0; cur_word = '0; discarded = 1'b0;
        exp_a = 12'h000; exp_b = 12'h000;
        tick(4);
        chk_regs("R1 reset zero");
        chk("R1 sdo reset", {15'h0, sdata_out}, 16'h0);
        rst_n = 1'b1;
        tick(4);

        // R4 strobe-select mode
        send_word(16'h0ABC, -1); strobe(1, 0);
        send_word(16'h0123, -1); strobe(0, 1);
        send_word(16'h1FFF, -1); strobe(1, 1);   // R8 bit 12 set

        // R5 address-select decoding
        send_word(16'hC456, -1); strobe(0, 1);   // A only
        send_word(16'hA789, -1); strobe(1, 0);   // B only
        send_word(16'hE321, -1); strobe(1, 1);   // both
        send_word(16'h8FFF, -1); strobe(1, 0);   // none
        send_word(16'hB5A5, -1); strobe(0, 1);   // R8 bit 12 with B only

        // R2 clock activity with select high
        send_word(16'h0555, -1);
        sdata_in = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sclk = 1'b1; tick(6); sclk = 1'b0; tick(6);
        end
        tick(6);
        strobe(1, 0);                            // R2 loads the held word
        send_word(16'h0666, -1);                 // R2 chain check expects 0x0555
        strobe(0, 1);

        // R6 strobe violation mid-frame
        send_word(16'h0AAA, 7);
        strobe(1, 1);
        strobe(1, 0);
        send_word(16'h0BBB, -1);                 // R7 still sees the discarded word
        strobe(1, 0);

        // R1 midscale and zero reset
        do_reset(1'b1);
        send_word(16'h0321, -1); strobe(0, 1);
        do_reset(1'b0);

        // random frames mixed with occasional violations
        for (int n = 0; n < 40; n++) begin
            logic [15:0] w;
            int sel;
            w = 16'($urandom);
            sel = int'($urandom % 3) + 1;
            send_word(w, (($urandom % 8) == 0) ? int'($urandom % 16) : -1);
            strobe(sel[0], sel[1]);
        end

        finish_run();
    end
endmodule